// File: doc/BRIEF.md
# Latched-Vector Interrupt Controller

This block gathers 128 level-sensitive interrupt lines into a single interrupt request for a processor. The lines are grouped into four banks of 32. Each bank has a 32-bit register window on a simple word bus. Through that window software reads the raw lines, reads the mask bits, and changes the masks through a write-one-to-set port and a write-one-to-clear port. It can also force a line active through a software-set port and release it through a software-clear port. It reads the masked pending status as well.

When an agreement is open, the controller picks the lowest-numbered pending source. It latches that number into an active-vector register and raises its request output. The number stays frozen until software writes the new-agreement command. The request then drops for at least one cycle and arbitration runs again.

If no source was agreed, the active-vector word carries all ones in its upper bits, which marks the result as spurious. A soft-reset command returns all software state to its reset values. A status bit shows when that reset has finished.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, every mask bit is 1 and every software-set bit is 0. The active word at 0x40 reads 0xFFFFFF80, irq_out is low, and bit 0 of the status word at 0x14 reads 1.
- R2: Bank b has its window at 0x80+0x20·b, and source n maps to bank n/32, bit n%32. Writing ones to mask-clear (+0x08) clears the matching mask bits. Writing ones to mask-set (+0x0C) sets them. Zero bits leave the mask unchanged. The mask reads back at +0x04.
- R3: Writing ones to software-set (+0x10) forces those sources to request, and writing ones to software-clear (+0x14) releases them. The software-set bits read back at +0x10.
- R4: Offset +0x00 of a bank reads that bank's raw input lines.
- R5: Offset +0x18 reads (raw OR software-set) AND NOT mask. Offset +0x1C always reads zero.
- R6: While an agreement is open, the lowest-numbered pending source is captured on the next clock edge. The active word then reads the number in bits 6:0 with bits 31:7 at zero.
- R7: Once captured, the active number and irq_out stay fixed while pending inputs change. This holds even when the agreed source goes away.
- R8: Writing 1 to bit 0 of the control word at 0x48 opens a new agreement. irq_out is low in the cycle after the write, and arbitration runs on the following edge. If nothing is pending, the active word reads 0xFFFFFF80.
- R9: irq_out is high exactly while a valid agreed number is latched.
- R10: Writing 1 to bit 1 of the config word at 0x10 starts a soft reset. Status bit 0 reads 0 for one cycle. It then reads 1, with masks, software-set bits and the active word back at their R1 values.
- R11: The words at 0x10, 0x44, 0x48, 0x68 and 0x100 and above read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the accessed word |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_in | input | 128 | Level-sensitive interrupt lines |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The bench drives the lowest- and highest-numbered sources and several mixed patterns. A priority encoder scanning the wrong way, or one that drops the top bit, returns the wrong vector. It raises a lower-numbered source after an agreement and then removes the agreed one. A design that re-arbitrates without the command would change the vector or drop the request. It checks that the request falls right after a new-agreement write and that an empty agreement gives the spurious word; a design that latched a stale number would keep the request up. It checks that a soft reset shows its busy cycle and restores all masks. It also checks that write-one ports ignore zero bits; a plain-write mask would clear neighbours.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int NSRC = 128,
  parameter int AW   = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NSRC-1:0] src_in,
  output logic            irq_out
);
  localparam int NB = NSRC / 32;
  localparam int IW = $clog2(NSRC);
  localparam int BW = AW - 5;
  localparam logic [AW-1:0] A_CFG  = AW'('h10);
  localparam logic [AW-1:0] A_STAT = AW'('h14);
  localparam logic [AW-1:0] A_ACT  = AW'('h40);
  localparam logic [AW-1:0] A_CTL  = AW'('h48);
  localparam logic [AW-1:0] A_BANK = AW'('h80);
  localparam logic [AW-1:0] A_END  = AW'('h80 + NB * 32);

  logic [NSRC-1:0] mask_q, swset_q, pend;
  logic [IW-1:0]   act_num, win;
  logic            act_valid, armed, srst_busy, hit;

  logic [AW-1:0] boff;
  logic [BW-1:0] bidx;
  logic [2:0]    word;
  logic          in_bank, newagr_wr, srst_wr;

  assign pend      = (src_in | swset_q) & ~mask_q;
  assign in_bank   = (bus_addr >= A_BANK) && (bus_addr < A_END);
  assign boff      = bus_addr - A_BANK;
  assign bidx      = boff[AW-1:5];
  assign word      = boff[4:2];
  assign newagr_wr = bus_wr && (bus_addr == A_CTL) && bus_wdata[0];
  assign srst_wr   = bus_wr && (bus_addr == A_CFG) && bus_wdata[1];
  assign irq_out   = act_valid;

  always_comb begin
    win = '0;
    hit = 1'b0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        win = IW'(i);
        hit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '1;
      swset_q <= '0;
    end else if (srst_busy) begin
      mask_q  <= '1;
      swset_q <= '0;
    end else if (bus_wr && in_bank) begin
      for (int b = 0; b < NB; b++) begin
        if (bidx == BW'(b)) begin
          case (word)
            3'd2: mask_q[b*32 +: 32]  <= mask_q[b*32 +: 32] & ~bus_wdata;
            3'd3: mask_q[b*32 +: 32]  <= mask_q[b*32 +: 32] | bus_wdata;
            3'd4: swset_q[b*32 +: 32] <= swset_q[b*32 +: 32] | bus_wdata;
            3'd5: swset_q[b*32 +: 32] <= swset_q[b*32 +: 32] & ~bus_wdata;
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_valid <= 1'b0;
      act_num   <= '0;
      armed     <= 1'b1;
      srst_busy <= 1'b0;
    end else begin
      srst_busy <= srst_wr && !srst_busy;
      if (srst_busy || newagr_wr) begin
        act_valid <= 1'b0;
        act_num   <= '0;
        armed     <= 1'b1;
      end else if (armed && hit) begin
        act_valid <= 1'b1;
        act_num   <= win;
        armed     <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (in_bank) begin
      for (int b = 0; b < NB; b++) begin
        if (bidx == BW'(b)) begin
          case (word)
            3'd0: bus_rdata = src_in[b*32 +: 32];
            3'd1: bus_rdata = mask_q[b*32 +: 32];
            3'd4: bus_rdata = swset_q[b*32 +: 32];
            3'd6: bus_rdata = pend[b*32 +: 32];
            default: bus_rdata = '0;
          endcase
        end
      end
    end else if (bus_addr == A_STAT) begin
      bus_rdata = {31'b0, ~srst_busy};
    end else if (bus_addr == A_ACT) begin
      bus_rdata = act_valid ? {{(32-IW){1'b0}}, act_num}
                            : {{(32-IW){1'b1}}, {IW{1'b0}}};
    end
  end
endmodule

module irq_vector_ctrl_chk #(
  parameter int NSRC = 128,
  parameter int IW   = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq_out,
  input logic            newagr_wr,
  input logic            srst_busy,
  input logic [IW-1:0]   act_num,
  input logic [NSRC-1:0] pend,
  input logic [NSRC-1:0] mask_q,
  input logic [NSRC-1:0] swset_q
);
  logic [NSRC-1:0] pend_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend;

  assert_drop_after_agree_R8: assert property (@(posedge clk) disable iff (!rst_n)
    newagr_wr |=> !irq_out);

  assert_vector_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && !newagr_wr && !srst_busy) |=> (irq_out && $stable(act_num)));

  assert_lowest_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> (pend_q[act_num] &&
      ((pend_q & ((NSRC'(1) << act_num) - NSRC'(1))) == '0)));

  assert_soft_reset_restores_R10: assert property (@(posedge clk) disable iff (!rst_n)
    srst_busy |=> (mask_q == '1 && swset_q == '0 && !irq_out));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.NSRC(NSRC), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_out(irq_out), .newagr_wr(newagr_wr),
  .srst_busy(srst_busy), .act_num(act_num), .pend(pend),
  .mask_q(mask_q), .swset_q(swset_q)
);

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [11:0]  bus_addr = '0;
  logic         bus_wr = 1'b0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [127:0] src_in = '0;
  logic         irq_out;
  int n_chk = 0, n_fail = 0;
  logic [31:0] d;

  irq_vector_ctrl dut (.*);

  always #2 clk = ~clk;

  localparam logic [31:0] SPUR = 32'hFFFF_FF80;
  localparam logic [159:0] VECS [6] = '{
    {128'h0000_0000_0000_0000_0000_0000_0000_0001, 32'h0000_0000},
    {128'h8000_0000_0000_0000_0000_0000_0000_0000, 32'h0000_007F},
    {128'h0000_0000_0000_0000_0000_0100_0000_0020, 32'h0000_0005},
    {128'h0000_0001_0000_0001_0000_0000_0000_0000, 32'h0000_0040},
    {128'h0000_0000_0000_0000_0000_0000_0000_0000, SPUR},
    {128'h8000_0000_0000_0000_0000_0002_0000_0000, 32'h0000_0021}
  };

  function automatic logic [11:0] bank(input int b, input int off);
    return 12'(32'h80 + 32'h20 * b + off);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(bank(0, 4), d); chk("R1 mask0", d, 32'hFFFF_FFFF);
    rd(bank(3, 4), d); chk("R1 mask3", d, 32'hFFFF_FFFF);
    rd(bank(1, 16), d); chk("R1 swset", d, 0);
    rd(12'h040, d); chk("R1 active", d, SPUR);
    chk("R1 irq", {31'b0, irq_out}, 0);
    rd(12'h014, d); chk("R1 status", d, 1);

    // R4 raw readback
    src_in = {32'h0, 32'h0, 32'hA5A5_0F0F, 32'h0};
    @(negedge clk);
    rd(bank(1, 0), d); chk("R4 raw", d, 32'hA5A5_0F0F);

    // R2 write-one masks, zero bits untouched
    wr(bank(1, 8), 32'h0000_00F0);
    rd(bank(1, 4), d); chk("R2 clr", d, 32'hFFFF_FF0F);
    wr(bank(1, 12), 32'h0000_0010);
    rd(bank(1, 4), d); chk("R2 set", d, 32'hFFFF_FF1F);
    rd(bank(0, 4), d); chk("R2 other bank", d, 32'hFFFF_FFFF);

    // R5 pending = raw & ~mask
    rd(bank(1, 24), d); chk("R5 pend", d, 32'h0000_0000);
    wr(bank(1, 8), 32'hFFFF_FFFF);
    rd(bank(1, 24), d); chk("R5 pend open", d, 32'hA5A5_0F0F);
    rd(bank(1, 28), d); chk("R5 fiq zero", d, 0);
    src_in = '0;
    for (int b = 0; b < 4; b++) wr(bank(b, 8), 32'hFFFF_FFFF);

    // R6 / R9 vector table
    for (int i = 0; i < 6; i++) begin
      src_in = VECS[i][159:32];
      wr(12'h048, 32'h1);
      chk("R8 irq low after agree", {31'b0, irq_out}, 0);
      @(negedge clk);
      rd(12'h040, d); chk("R6 vector", d, VECS[i][31:0]);
      chk("R9 irq", {31'b0, irq_out}, {31'b0, VECS[i][31:0] != SPUR});
    end

    // R7 latched vector ignores changes
    src_in = '0; src_in[10] = 1'b1;
    wr(12'h048, 32'h1);
    @(negedge clk);
    src_in[3] = 1'b1;
    repeat (3) @(negedge clk);
    rd(12'h040, d); chk("R7 hold lower", d, 32'd10);
    src_in[10] = 1'b0;
    repeat (2) @(negedge clk);
    rd(12'h040, d); chk("R7 hold removed", d, 32'd10);
    chk("R7 irq held", {31'b0, irq_out}, 1);
    wr(12'h048, 32'h1);
    chk("R8 drop", {31'b0, irq_out}, 0);
    @(negedge clk);
    rd(12'h040, d); chk("R8 rearb", d, 32'd3);

    // R3 software set/clear
    src_in = '0;
    wr(bank(2, 16), 32'h0000_0010);
    rd(bank(2, 16), d); chk("R3 swset", d, 32'h10);
    rd(bank(2, 24), d); chk("R3 pend", d, 32'h10);
    wr(12'h048, 32'h1);
    @(negedge clk);
    rd(12'h040, d); chk("R3 vector", d, 32'd68);
    wr(bank(2, 20), 32'h0000_0010);
    rd(bank(2, 16), d); chk("R3 swclr", d, 0);

    // R8 empty agreement
    wr(12'h048, 32'h1);
    @(negedge clk);
    rd(12'h040, d); chk("R8 spurious", d, SPUR);
    chk("R8 irq", {31'b0, irq_out}, 0);

    // R11 unused words
    rd(12'h010, d); chk("R11 cfg", d, 0);
    rd(12'h044, d); chk("R11 fiq", d, 0);
    rd(12'h048, d); chk("R11 ctl", d, 0);
    rd(12'h068, d); chk("R11 thr", d, 0);
    rd(12'h100, d); chk("R11 level", d, 0);

    // R10 soft reset
    wr(bank(0, 16), 32'h0000_0004);
    wr(12'h048, 32'h1);
    @(negedge clk);
    chk("R10 pre irq", {31'b0, irq_out}, 1);
    wr(12'h010, 32'h2);
    rd(12'h014, d); chk("R10 busy", d, 0);
    @(negedge clk);
    rd(12'h014, d); chk("R10 done", d, 1);
    rd(bank(0, 4), d); chk("R10 mask", d, 32'hFFFF_FFFF);
    rd(bank(0, 16), d); chk("R10 swset", d, 0);
    rd(12'h040, d); chk("R10 active", d, SPUR);
    chk("R10 irq", {31'b0, irq_out}, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule